// File: doc/BRIEF.md
# Eight-bit accumulator processor core

This block is a small multi-cycle processor. Program and data share one external byte-wide memory of 32 locations. The core has a 5-bit address bus, active-low read and write strobes, and a bidirectional 8-bit data bus. It holds seven 8-bit working registers, a 5-bit program counter and an instruction register. An add/subtract unit works on the accumulator. A state machine steps through fetch, decode, an optional memory access, and writeback.

Instructions are single bytes. Bits 7..6 give the major opcode and the two 3-bit fields below them name registers. The field value 110 does not select a register. It selects the memory byte whose address is the low five bits of register L. The core executes register moves, moves to and from that memory operand, direct load and store of the accumulator, add and subtract into the accumulator, no-op, and halt. Once halted, the core stops all bus activity and stays stopped until a synchronous reset.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core returns to its start state. The program counter and all seven registers become 0, `halted` is low, `wr_n` is high, and the address bus shows 0. The first fetch after reset reads address 0.
- R2: A fetch holds `rd_n` low for one cycle with the program counter on `addr_o`. The core latches the byte on `data_io` as the instruction. The program counter then increments by one and wraps from 31 to 0.
- R3: Register field codes are A=111, B=000, C=001, D=010, E=011, H=100 and L=101. The byte 01 ddd sss copies register sss into register ddd.
- R4: The field code 110 names the memory byte at address L[4:0]. Bits 7..5 of L do not affect the address. The byte 01 110 sss writes register sss to that byte. The byte 01 ddd 110 loads that byte into register ddd.
- R5: The byte 10 000 sss adds its operand to A, and 10 010 sss subtracts its operand from A. The operand is register sss, or the memory operand when sss=110. The result wraps modulo 256.
- R6: The byte 001 aaaaa loads A from address aaaaa. The byte 111 aaaaa stores A to address aaaaa.
- R7: The byte 0x00 only advances the program counter. These encodings also behave as that no-op: major opcode 10 with a middle field other than 000 or 010, and major opcode 00 or 11 with bit 5 clear.
- R8: The byte 01 110 110 halts the core. `halted` goes high in the cycle after that byte is decoded. From then until reset, neither strobe is asserted and `halted` stays high.
- R9: `rd_n` and `wr_n` are never low together. Each stays low for exactly one cycle per access. The core drives `data_io` only while `wr_n` is low, with address and data held for that whole cycle.
- R10: An instruction that uses only registers takes 2 cycles. An instruction that reads memory takes 4 cycles. An instruction that writes memory takes 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_o | output | 5 | Memory address |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| data_io | inout | 8 | Data bus, high impedance unless writing |
| halted | output | 1 | High after a halt instruction until reset |

## Verification
The registers cannot be seen from outside, so a wrong register value, a wrong decode or a wrong ALU result stays hidden until the program stores it. Each test program therefore ends by writing its result to address 31. The bench then compares the byte it captured at that address, one write cycle after the fault's effect reaches the accumulator. A wrong state sequence is visible much sooner. It shows up as a fetch at the wrong address, strobes that overlap, a write that lasts the wrong length, or `halted` rising at the wrong cycle. Each of these is visible on the strobes within the instruction where it happens.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int RW = 3;

  localparam logic [RW-1:0] CODE_A   = 3'b111;
  localparam logic [RW-1:0] CODE_L   = 3'b101;
  localparam logic [RW-1:0] CODE_MEM = 3'b110;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_MRD, S_WB, S_MWR, S_HALT
  } state_t;

  typedef enum logic [2:0] {
    K_NOP, K_MOV, K_ADD, K_SUB, K_LDA, K_STA, K_HLT
  } kind_t;

  function automatic logic [DW-1:0] acc_add(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DW-1:0] acc_sub(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x - y;
  endfunction
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [DW-1:0] ir,
  output kind_t         kind,
  output logic [RW-1:0] dst,
  output logic [RW-1:0] src,
  output logic          needs_rd,
  output logic          needs_wr,
  output logic          direct
);
  logic src_m, dst_m;

  assign dst   = ir[5:3];
  assign src   = ir[2:0];
  assign src_m = (src == CODE_MEM);
  assign dst_m = (dst == CODE_MEM);

  always_comb begin
    kind = K_NOP;
    unique case (ir[7:6])
      2'b01: kind = (src_m && dst_m) ? K_HLT : K_MOV;
      2'b10: begin
        if (dst == 3'b000)      kind = K_ADD;
        else if (dst == 3'b010) kind = K_SUB;
      end
      2'b00: if (ir[5]) kind = K_LDA;
      2'b11: if (ir[5]) kind = K_STA;
      default: kind = K_NOP;
    endcase
  end

  assign needs_rd = ((kind == K_MOV || kind == K_ADD || kind == K_SUB) && src_m) || (kind == K_LDA);
  assign needs_wr = (kind == K_MOV && dst_m) || (kind == K_STA);
  assign direct   = (kind == K_LDA) || (kind == K_STA);
endmodule

// File: rtl/acc8_regfile.sv
module acc8_regfile
  import acc8_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] ssel,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] l_q
);
  localparam int NSLOT = 1 << RW;
  logic [DW-1:0] q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i == int'(CODE_MEM)) begin : g_hole
      assign q[i] = '0;
    end else begin : g_reg
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)                            r <= '0;
        else if (we && wsel == RW'(i))      r <= wdata;
      end
      assign q[i] = r;
    end
  end

  assign src_q = q[ssel];
  assign a_q   = q[CODE_A];
  assign l_q   = q[CODE_L];
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] addr_o,
  output logic          rd_n,
  output logic          wr_n,
  inout  wire  [DW-1:0] data_io,
  output logic          halted
);
  state_t        state;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, mdr;

  kind_t         kind;
  logic [RW-1:0] dst, src;
  logic          needs_rd, needs_wr, direct;

  logic          rf_we;
  logic [RW-1:0] rf_wsel;
  logic [DW-1:0] rf_wdata, src_q, a_q, l_q, opnd, wdata;
  logic [AW-1:0] mem_addr;

  // named events for the checker
  logic fetch_ev, hlt_ev, drive_en;

  acc8_decode u_dec (
    .ir(ir), .kind(kind), .dst(dst), .src(src),
    .needs_rd(needs_rd), .needs_wr(needs_wr), .direct(direct)
  );

  acc8_regfile u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wsel(rf_wsel), .wdata(rf_wdata),
    .ssel(src), .src_q(src_q), .a_q(a_q), .l_q(l_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      mdr   <= '0;
    end else begin
      unique case (state)
        S_FETCH: begin
          ir    <= data_io;
          pc    <= pc + 1'b1;
          state <= S_DECODE;
        end
        S_DECODE: begin
          if (kind == K_HLT)  state <= S_HALT;
          else if (needs_rd)  state <= S_MRD;
          else if (needs_wr)  state <= S_MWR;
          else                state <= S_FETCH;
        end
        S_MRD: begin
          mdr   <= data_io;
          state <= S_WB;
        end
        S_WB:    state <= S_FETCH;
        S_MWR:   state <= S_FETCH;
        S_HALT:  state <= S_HALT;
        default: state <= S_FETCH;
      endcase
    end
  end

  assign fetch_ev = (state == S_FETCH);
  assign hlt_ev   = (state == S_DECODE) && (kind == K_HLT);
  assign drive_en = (state == S_MWR);

  assign mem_addr = direct ? ir[AW-1:0] : l_q[AW-1:0];
  assign addr_o   = fetch_ev ? pc : mem_addr;
  assign rd_n     = !(fetch_ev || state == S_MRD);
  assign wr_n     = !drive_en;
  assign halted   = (state == S_HALT);

  assign wdata   = (kind == K_STA) ? a_q : src_q;
  assign data_io = drive_en ? wdata : {DW{1'bz}};

  assign opnd = (state == S_WB) ? mdr : src_q;

  always_comb begin
    rf_we    = 1'b0;
    rf_wsel  = CODE_A;
    rf_wdata = opnd;
    if ((state == S_DECODE && !needs_rd && !needs_wr) || state == S_WB) begin
      unique case (kind)
        K_MOV: begin rf_we = 1'b1; rf_wsel = dst; rf_wdata = opnd; end
        K_ADD: begin rf_we = 1'b1; rf_wdata = acc_add(a_q, opnd); end
        K_SUB: begin rf_we = 1'b1; rf_wdata = acc_sub(a_q, opnd); end
        K_LDA: begin rf_we = 1'b1; rf_wdata = opnd; end
        default: rf_we = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk
  import acc8_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          rd_n,
  input logic          wr_n,
  input logic          halted,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] pc,
  input logic          fetch_ev,
  input logic          hlt_ev,
  input logic          drive_en
);
  assert_fetch_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_ev |=> (pc == $past(pc) + 1'b1));

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_ev |-> (!rd_n && addr_o == pc));

  assert_halt_follows_R8: assert property (@(posedge clk) disable iff (rst)
    hlt_ev |=> halted);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (rd_n && wr_n));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  assert_rd_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_n |=> rd_n);

  assert_wr_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> wr_n);

  assert_bus_only_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    drive_en == !wr_n);
endmodule

bind acc8_core acc8_core_chk u_chk (
  .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .halted(halted),
  .addr_o(addr_o), .pc(pc), .fetch_ev(fetch_ev), .hlt_ev(hlt_ev),
  .drive_en(drive_en)
);

// File: tb/tb_acc8_core.sv
module tb_acc8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr;
  logic       rd_n, wr_n, halted;
  wire  [7:0] bus;
  logic [7:0] mem [32];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  acc8_core dut (
    .clk(clk), .rst(rst), .addr_o(addr), .rd_n(rd_n), .wr_n(wr_n),
    .data_io(bus), .halted(halted)
  );

  assign bus = rd_n ? 8'hzz : mem[addr];
  always @(posedge clk) if (!wr_n) mem[addr] <= bus;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector: 8 program bytes, byte at 29, byte at 30, expected byte at 31
  localparam int NV = 8;
  localparam logic [87:0] VEC [NV] = '{
    {8'h3E,8'h87,8'hFF,8'h76,8'h76,8'h76,8'h76,8'h76, 8'h00,8'h25, 8'h4A}, // R5 R6 add reg
    {8'h3E,8'h47,8'h90,8'hFF,8'h76,8'h76,8'h76,8'h76, 8'h00,8'h5C, 8'h00}, // R3 R5 sub reg
    {8'h3D,8'h6F,8'h3E,8'h86,8'hFF,8'h76,8'h76,8'h76, 8'h1E,8'h90, 8'h20}, // R4 R5 add M wrap
    {8'h3D,8'h4F,8'h3E,8'h91,8'hFF,8'h76,8'h76,8'h76, 8'h05,8'h03, 8'hFE}, // R5 sub wrap
    {8'h3D,8'h6F,8'h3E,8'h77,8'h76,8'h76,8'h76,8'h76, 8'hFF,8'h81, 8'h81}, // R4 MOV M,A, L[7:5] ignored
    {8'h3D,8'h6F,8'h5E,8'h63,8'h7C,8'hFF,8'h76,8'h76, 8'h3E,8'h6B, 8'h6B}, // R3 R4 MOV r,M chain
    {8'h3D,8'h6F,8'h3E,8'h96,8'hFF,8'h76,8'h76,8'h76, 8'h1D,8'h10, 8'hF3}, // R5 sub M
    {8'h3E,8'hA5,8'h05,8'hC3,8'h00,8'hFF,8'h76,8'h76, 8'h00,8'h77, 8'h77}  // R7 unlisted = nop
  };

  task automatic load(input logic [63:0] prog, input logic [7:0] d29, input logic [7:0] d30);
    for (int i = 0; i < 32; i++) mem[i] = 8'h76;
    for (int i = 0; i < 8; i++) mem[i] = prog[63-8*i -: 8];
    mem[29] = d29;
    mem[30] = d30;
    mem[31] = 8'hEE;
  endtask

  // reset, then run until halted; returns cycles to halt and number of write cycles
  task automatic run(output int cyc, output int nwr);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0; nwr = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (!wr_n) nwr++;
      if (!rd_n && !wr_n) check(1'b0, "R9 strobe overlap", 0, 1);
    end
  endtask

  initial begin
    int cyc, nwr;
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R1 halted in reset", halted, 0);
    check(wr_n == 1'b1,   "R1 wr_n in reset", wr_n, 1);
    check(addr == 5'd0,   "R1 addr in reset", addr, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      load(VEC[v][87:24], VEC[v][23:16], VEC[v][15:8]);
      run(cyc, nwr);
      check(halted == 1'b1, "R8 halt reached", halted, 1);
      check(mem[31] == VEC[v][7:0], $sformatf("R3-vec%0d result", v), mem[31], VEC[v][7:0]);
    end

    // R1 registers cleared: store A immediately after reset
    load({8'hFF,8'h76,48'h767676767676}, 8'h00, 8'h00);
    mem[31] = 8'h5A;
    run(cyc, nwr);
    check(mem[31] == 8'h00, "R1 A zero after reset", mem[31], 0);

    // R6 direct store to a non-top address, R10 cycle counts
    load({8'h3E,8'hF4,8'h76,40'h7676767676}, 8'h00, 8'hC9);
    run(cyc, nwr);
    check(mem[20] == 8'hC9, "R6 STA to 20", mem[20], 8'hC9);
    check(cyc == 9, "R10 cycles to halt", cyc, 9);
    check(nwr == 1, "R9 one write cycle", nwr, 1);

    // R8 quiet after halt
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!rd_n || !wr_n || !halted) quiet = 1'b0;
      end
      check(quiet, "R8 no strobes while halted", quiet, 1);
    end

    // R2 fetch walk with wrap; R10 register-only spacing
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(halted == 1'b0, "R1 reset clears halt", halted, 0);
    rst = 1'b0;
    begin
      int nf = 0, last = -2, cyc2 = 0;
      bit seq_ok = 1'b1, gap_ok = 1'b1;
      while (nf < 34) begin
        if (!rd_n) begin
          if (int'(addr) != (nf % 32)) seq_ok = 1'b0;
          if (nf > 0 && cyc2 - last != 2) gap_ok = 1'b0;
          last = cyc2;
          nf++;
        end
        @(negedge clk);
        cyc2++;
      end
      check(seq_ok, "R2 fetch addresses wrap 31->0", seq_ok, 1);
      check(gap_ok, "R10 nop takes 2 cycles", gap_ok, 1);
      check(wr_n == 1'b1, "R7 nop writes nothing", wr_n, 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule